// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block turns one addressing-mode request into an operand value. A request carries a 4-bit mode code, a register number and a displacement word. The unit forms the effective address from those fields and from its own small register file. The file has one slot that serves as the program counter and one that serves as the stack pointer. The unit reads memory zero, one or two times through a synchronous request/response port, and returns the operand together with a one-cycle done pulse.

The two auto-stepping modes also rewrite their base register. The step size is given as a 2-bit power-of-two code. The same code acts as the scale factor for the scaled-index mode. A write port and a read port on the register file let the surrounding logic load bases and observe the stepped values. Mode codes outside the defined set are flagged as illegal and leave memory and registers untouched.

Top module: `opfetch_unit`

## Requirements
- R1: Mode code 0 (immediate) returns the displacement as the operand. It makes no memory request, and done rises one cycle after the request is accepted.
- R2: Mode code 1 (direct) returns M[disp] using a single read at address disp.
- R3: Mode code 2 (register indirect) returns M[Rr] using a single read, where Rr is the content of the addressed register.
- R4: Mode code 3 (memory indirect) makes two reads. The first is at disp, and the data it returns is the address of the second. The operand is the data of the second read.
- R5: Mode code 4 (post-increment) reads at Rr and returns that data. It writes Rr+n back to the addressed register, where n = 1 << size code (0→1, 1→2, 2→4, 3→8). The new value is visible on the register read port in the done cycle.
- R6: Mode code 5 (pre-decrement) reads at Rr−n and returns that data. It writes Rr−n back to the addressed register, with n as in R5, visible in the done cycle.
- R7: Mode code 6 (indexed) reads at Rr+disp. Mode code 7 (scaled index) reads at (Rr << size code)+disp. All address arithmetic wraps at the data width.
- R8: Mode code 8 reads at R6+disp (slot 6 is the program counter). Mode code 9 reads at R7+disp (slot 7 is the stack pointer). For both codes the register field of the request has no effect.
- R9: Mode codes 10 to 15 produce done with the illegal flag set and an operand of zero. They make no memory request and change no register.
- R10: A memory request stays valid with a stable address until it is accepted. The unit accepts a new request only while idle. Done is asserted exactly one cycle after the last memory response of an operation.
- R11: The register write port loads any slot, and the register read port shows slot contents combinationally. After reset every slot is zero, the unit is idle and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_mode | input | 4 | Addressing mode code |
| req_reg | input | 3 | Base register number |
| req_disp | input | DW | Displacement / address / immediate |
| req_size | input | 2 | log2 of step size or scale |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | DW | Memory read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DW | Read data |
| done | output | 1 | Operand valid pulse |
| operand | output | DW | Fetched operand |
| illegal | output | 1 | Mode code undefined, with done |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register file write slot |
| rf_wdata | input | DW | Register file write data |
| rf_raddr | input | 3 | Register file read slot |
| rf_rdata | output | DW | Register file read data |

## Verification
A wrong address computation shows up on mem_addr in the very cycle the request is issued. It shows one cycle later as a wrong operand, because the bench memory returns data that is a known function of the address. A bad base write-back appears on the register read port in the done cycle, and it corrupts every later operation that uses that slot. A phase error in the two-read mode shows up as a wrong read count or as a second address that differs from the first read's data. The sweep covers every mode code, every size code, several registers including both special slots, and displacements that force wraparound.

// File: rtl/opf_pkg.sv
package opf_pkg;
    localparam logic [3:0] MD_IMM  = 4'd0;
    localparam logic [3:0] MD_DIR  = 4'd1;
    localparam logic [3:0] MD_RIND = 4'd2;
    localparam logic [3:0] MD_MIND = 4'd3;
    localparam logic [3:0] MD_AINC = 4'd4;
    localparam logic [3:0] MD_ADEC = 4'd5;
    localparam logic [3:0] MD_IDX  = 4'd6;
    localparam logic [3:0] MD_SIB  = 4'd7;
    localparam logic [3:0] MD_PCR  = 4'd8;
    localparam logic [3:0] MD_SPR  = 4'd9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } fsm_t;

    typedef struct packed {
        logic legal;
        logic uses_mem;
        logic two_reads;
        logic writes_base;
        logic use_pc;
        logic use_sp;
    } mode_info_t;
endpackage

// File: rtl/opf_mode_dec.sv
module opf_mode_dec
    import opf_pkg::*;
(
    input  logic [3:0]  mode,
    output mode_info_t  info
);
    always_comb begin
        info = '0;
        info.legal       = (mode <= MD_SPR);
        info.uses_mem    = info.legal && (mode != MD_IMM);
        info.two_reads   = (mode == MD_MIND);
        info.writes_base = (mode == MD_AINC) || (mode == MD_ADEC);
        info.use_pc      = (mode == MD_PCR);
        info.use_sp      = (mode == MD_SPR);
    end
endmodule

// File: rtl/opf_ea.sv
module opf_ea
    import opf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]    mode,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] disp,
    input  logic [1:0]    lg,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] new_base
);
    logic [DW-1:0] step;

    always_comb begin
        step     = DW'(1) << lg;
        new_base = base;
        case (mode)
            MD_DIR, MD_MIND:        addr = disp;
            MD_RIND:                addr = base;
            MD_AINC: begin
                addr     = base;
                new_base = base + step;
            end
            MD_ADEC: begin
                addr     = base - step;
                new_base = base - step;
            end
            MD_IDX, MD_PCR, MD_SPR: addr = base + disp;
            MD_SIB:                 addr = (base << lg) + disp;
            default:                addr = '0;
        endcase
    end
endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
    import opf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [3:0]              req_mode,
    input  logic [$clog2(NREG)-1:0] req_reg,
    input  logic [DW-1:0]           req_disp,
    input  logic [1:0]              req_size,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [DW-1:0]           mem_addr,
    input  logic                    mem_rsp_valid,
    input  logic [DW-1:0]           mem_rsp_data,
    output logic                    done,
    output logic [DW-1:0]           operand,
    output logic                    illegal,
    input  logic                    rf_we,
    input  logic [$clog2(NREG)-1:0] rf_waddr,
    input  logic [DW-1:0]           rf_wdata,
    input  logic [$clog2(NREG)-1:0] rf_raddr,
    output logic [DW-1:0]           rf_rdata
);
    localparam int RW     = $clog2(NREG);
    localparam int PC_IDX = NREG - 2;
    localparam int SP_IDX = NREG - 1;

    typedef struct packed {
        fsm_t                     st;
        logic [DW-1:0]            addr;
        logic                     second;
        logic                     two;
        logic                     wb;
        logic [RW-1:0]            wb_idx;
        logic [DW-1:0]            wb_val;
        logic [DW-1:0]            operand;
        logic                     done;
        logic                     illegal;
        logic [NREG-1:0][DW-1:0]  rf;
    } state_t;

    state_t        s_q, s_d;
    mode_info_t    info;
    logic [DW-1:0] base, ea_addr, ea_new;

    opf_mode_dec u_dec (
        .mode (req_mode),
        .info (info)
    );

    always_comb begin
        if (info.use_pc)      base = s_q.rf[PC_IDX];
        else if (info.use_sp) base = s_q.rf[SP_IDX];
        else                  base = s_q.rf[req_reg];
    end

    opf_ea #(.DW(DW)) u_ea (
        .mode     (req_mode),
        .base     (base),
        .disp     (req_disp),
        .lg       (req_size),
        .addr     (ea_addr),
        .new_base (ea_new)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.illegal = 1'b0;
        if (rf_we) s_d.rf[rf_waddr] = rf_wdata;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!info.legal) begin
                        s_d.done    = 1'b1;
                        s_d.illegal = 1'b1;
                        s_d.operand = '0;
                    end else if (!info.uses_mem) begin
                        s_d.done    = 1'b1;
                        s_d.operand = req_disp;
                    end else begin
                        s_d.st     = ST_REQ;
                        s_d.addr   = ea_addr;
                        s_d.second = 1'b0;
                        s_d.two    = info.two_reads;
                        s_d.wb     = info.writes_base;
                        s_d.wb_idx = req_reg;
                        s_d.wb_val = ea_new;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (s_q.two && !s_q.second) begin
                        s_d.second = 1'b1;
                        s_d.addr   = mem_rsp_data;
                        s_d.st     = ST_REQ;
                    end else begin
                        s_d.st      = ST_IDLE;
                        s_d.done    = 1'b1;
                        s_d.operand = mem_rsp_data;
                        if (s_q.wb) s_d.rf[s_q.wb_idx] = s_q.wb_val;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready     = (s_q.st == ST_IDLE);
    assign mem_req_valid = (s_q.st == ST_REQ);
    assign mem_addr      = s_q.addr;
    assign done          = s_q.done;
    assign operand       = s_q.operand;
    assign illegal       = s_q.illegal;
    assign rf_rdata      = s_q.rf[rf_raddr];
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [DW-1:0] mem_addr,
    input logic          mem_rsp_valid,
    input logic          done,
    input logic [DW-1:0] operand,
    input logic          illegal
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R10

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R10

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid) || $past(req_valid && req_ready)); // R10

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && operand == '0); // R9

    AST_ILLEGAL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !$past(mem_rsp_valid)); // R9
endmodule

bind opfetch_unit opf_checker #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .operand       (operand),
    .illegal       (illegal)
);

// File: tb/sim_opfetch_unit.sv
`timescale 1ns/1ps
module sim_opfetch_unit;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [3:0]    req_mode = '0;
    logic [2:0]    req_reg = '0;
    logic [DW-1:0] req_disp = '0;
    logic [1:0]    req_size = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [DW-1:0] mem_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          done;
    logic [DW-1:0] operand;
    logic          illegal;
    logic          rf_we = 1'b0;
    logic [2:0]    rf_waddr = '0;
    logic [DW-1:0] rf_wdata = '0;
    logic [2:0]    rf_raddr = '0;
    logic [DW-1:0] rf_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    opfetch_unit #(.DW(DW), .NREG(8)) u0 (.*);

    function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
        return (a * 16'd37) ^ 16'h3c5a;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder, runs at the falling edge
    int            tick = 0;
    int            reads = 0;
    logic [DW-1:0] raddr [2];
    logic          seen_valid = 1'b0;
    logic [DW-1:0] seen_addr = '0;
    logic          pend = 1'b0;
    int            pend_cnt = 0;
    logic [DW-1:0] pend_addr = '0;
    logic          prev_rsp = 1'b0;

    always @(negedge clk) begin
        tick++;
        prev_rsp = mem_rsp_valid;
        mem_rsp_valid = 1'b0;
        if (seen_valid && !mem_req_ready && rst_n) begin
            check("R10 hold valid", {15'd0, mem_req_valid}, 16'd1);
            check("R10 stable addr", mem_addr, seen_addr);
        end
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memf(pend_addr);
                pend = 1'b0;
            end else begin
                pend_cnt--;
            end
        end
        if (seen_valid && mem_req_ready) begin
            if (reads < 2) raddr[reads] = seen_addr;
            reads++;
            pend      = 1'b1;
            pend_cnt  = tick % 3;
            pend_addr = seen_addr;
        end
        mem_req_ready = (tick % 3) != 0;
        seen_valid    = mem_req_valid;
        seen_addr     = mem_addr;
    end

    logic [DW-1:0] model [8];

    task automatic load_reg(input int idx, input logic [DW-1:0] val);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = 3'(idx); rf_wdata = val;
        @(negedge clk);
        rf_we = 1'b0;
        model[idx] = val;
        rf_raddr = 3'(idx);
        #1;
        check("R11 load", rf_rdata, val);
    endtask

    task automatic do_op(input int mode, input int r, input logic [DW-1:0] d, input int lg);
        logic [DW-1:0] base, ea, nb, exp_op, step;
        int exp_reads, cyc, wbi;
        logic exp_ill, wb;
        string tag;
        step = DW'(1) << lg;
        base = (mode == 8) ? model[6] : (mode == 9) ? model[7] : model[r];
        nb = base; wb = 1'b0; exp_ill = 1'b0; exp_reads = 1; ea = '0;
        case (mode)
            0: begin exp_reads = 0; tag = "R1"; end
            1: begin ea = d; tag = "R2"; end
            2: begin ea = base; tag = "R3"; end
            3: begin ea = d; exp_reads = 2; tag = "R4"; end
            4: begin ea = base; nb = base + step; wb = 1'b1; tag = "R5"; end
            5: begin ea = base - step; nb = ea; wb = 1'b1; tag = "R6"; end
            6: begin ea = base + d; tag = "R7"; end
            7: begin ea = (base << lg) + d; tag = "R7"; end
            8, 9: begin ea = base + d; tag = "R8"; end
            default: begin exp_reads = 0; exp_ill = 1'b1; tag = "R9"; end
        endcase
        if (mode == 0) exp_op = d;
        else if (exp_ill) exp_op = '0;
        else if (mode == 3) exp_op = memf(memf(d));
        else exp_op = memf(ea);
        wbi = r;

        @(negedge clk);
        check("R10 ready idle", {15'd0, req_ready}, 16'd1);
        reads = 0;
        req_valid = 1'b1; req_mode = 4'(mode); req_reg = 3'(r);
        req_disp = d; req_size = 2'(lg);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk); #1; cyc++;
        end
        if (!done) begin
            check({tag, " done timeout"}, 16'd0, 16'd1);
            return;
        end
        check({tag, " operand"}, operand, exp_op);
        check({tag, " illegal"}, {15'd0, illegal}, {15'd0, exp_ill});
        check({tag, " reads"}, 16'(reads), 16'(exp_reads));
        if (exp_reads >= 1) begin
            check({tag, " first addr"}, raddr[0], ea);
            check("R10 done after rsp", {15'd0, prev_rsp}, 16'd1);
        end else if (mode == 0) begin
            check("R1 done in one cycle", 16'(cyc), 16'd0);
        end
        if (exp_reads == 2) check("R4 second addr", raddr[1], memf(d));
        if (wb) model[wbi] = nb;
        rf_raddr = 3'(wbi);
        #1;
        check({tag, " reg after op"}, rf_rdata, model[wbi]);
    endtask

    initial begin
        #20_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] disps [3];
        disps[0] = 16'h0010; disps[1] = 16'hfff8; disps[2] = 16'h0000;
        #12;
        // R11 reset state
        check("R11 reset ready", {15'd0, req_ready}, 16'd1);
        check("R11 reset done", {15'd0, done}, 16'd0);
        check("R11 reset memreq", {15'd0, mem_req_valid}, 16'd0);
        for (int i = 0; i < 8; i++) begin
            rf_raddr = 3'(i); #1;
            check("R11 reset reg", rf_rdata, 16'd0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) load_reg(i, 16'h1000 + 16'(i * 16'h0111));
        load_reg(3, 16'h0003);
        load_reg(7, 16'hfffe);
        for (int m = 0; m < 16; m++)
            for (int lg = 0; lg < 4; lg++)
                for (int ri = 0; ri < 4; ri++)
                    for (int di = 0; di < 3; di++)
                        do_op(m, (ri == 0) ? 0 : (ri == 1) ? 3 : (ri == 2) ? 6 : 7,
                              disps[di], lg);
        // R8: register field has no effect on the special-slot modes
        do_op(8, 1, 16'h0040, 0);
        do_op(9, 2, 16'h0040, 0);
        #20;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule